// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Warning Interrupt and Reset Request

This block is a register-mapped watchdog with one tick counter and two compare thresholds. Once software turns it on, the counter advances by one every clock. When the count meets the first threshold (the warning point), a level interrupt is raised, provided that the interrupt is enabled. When the count meets the second threshold (the reset point), a one-cycle reset request pulse is issued. That pulse also sets a sticky status flag, which tells software after a reset that the watchdog caused it. Software keeps the system alive by writing the restart register at regular intervals. Each such write clears the counter and ends any pending warning.

Control is a four-state machine. The states are `WD_OFF` (disabled, counter held at zero), `WD_RUN` (counting, warning not yet reached), `WD_WARNED` (counting, warning point passed) and `WD_FIRED` (reset request issued, counter frozen). The transitions are:

- `WD_OFF` to `WD_RUN` when the run bit is set.
- `WD_RUN` to `WD_WARNED` when the count meets the warning threshold.
- `WD_RUN` or `WD_WARNED` to `WD_FIRED` when the count meets the reset threshold.
- Any active state to `WD_RUN` on a restart write.
- Any state to `WD_OFF` when the run bit is cleared.

The register bus is a single-cycle write port with a combinational read port. Reads return the register selected by the address.

Top module: `wdog_two_stage`

## Requirements
- R1: After `rst_n` is released, `bark_irq` and `bite_rst` are 0 and every register reads 0.
- R2: The register offsets are:
  - 0x04: restart. Reads as 0.
  - 0x08: control. Bit 0 is run and bit 1 is warning-interrupt enable. Both bits read back, and all other bits read 0.
  - 0x0C: status. Bit 0 is the sticky fired flag.
  - 0x10: warning threshold, read/write.
  - 0x14: reset threshold, read/write.

  Any other address reads 0, and writes to it change nothing.
- R3: The run bit is set by a write at clock edge E. With reset threshold B, `bite_rst` is high for exactly one cycle, starting at edge E+B+2, if no restart or control write intervenes.
- R4: With both control bits set and warning threshold A, `bark_irq` rises at edge E+A+2. It stays high until a restart or until the run bit is cleared. It rises at most once per count cycle, and it never rises while bit 1 is clear.
- R5: A write of bit 0 = 1 to the restart register at edge R clears the count. The next reset request then comes at edge R+B+1. A restart write with bit 0 = 0 has no effect.
- R6: Clearing the run bit stops the watchdog. `bark_irq` falls at the next edge, and from then on no warning and no reset request occur. Setting the run bit again counts from zero.
- R7: When the warning and reset thresholds are equal, the reset request still occurs. If bit 1 is set, the warning rises at the same edge.
- R8: When the warning threshold exceeds the reset threshold, the reset request occurs and no warning is raised.
- R9: After a reset request the counter holds its value. No further request occurs until a restart, or until the run bit is cleared and set again.
- R10: Status bit 0 becomes 1 at the same edge as the reset request pulse. Writing 1 to it clears it and writing 0 has no effect. If a clear and a new request fall on the same edge, the bit is set. Apart from that, only `rst_n` clears it.
- R11: The counter and thresholds are `CNT_W` bits wide, with a minimum of 29 (default 32). Values such as 0x10000000 are stored and read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and tick clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| bark_irq | output | 1 | Warning interrupt level |
| bite_rst | output | 1 | One-cycle reset request pulse |

## Verification
Directed sequences cover these cases:
- Separated thresholds, equal thresholds and inverted thresholds. These distinguish the warning path from the reset path and show which one wins on a tie.
- Restart writes with bit 0 both set and clear. These separate a real service from an ignored write.
- A status clear placed on the very edge of a reset request. This exposes the priority between set and clear.
- Large threshold values, which expose any truncation of the compare width.

Alongside this, random register traffic with mostly small thresholds produces many full count cycles. In it, disables, restarts and threshold changes land at arbitrary points in the count, and every output and read is compared each cycle against a reference model built from the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_RUN    = 2'd1,
        WD_WARNED = 2'd2,
        WD_FIRED  = 2'd3
    } wd_state_e;

    // Byte offsets of the registers; software depends on them.
    localparam int unsigned OFS_RESTART = 'h04;
    localparam int unsigned OFS_CTRL    = 'h08;
    localparam int unsigned OFS_STATUS  = 'h0C;
    localparam int unsigned OFS_WARN    = 'h10;
    localparam int unsigned OFS_FIRE    = 'h14;

    localparam int unsigned MIN_CNT_W = 29;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire_evt,
    output logic              en_run,
    output logic              en_irq,
    output logic [CNT_W-1:0]  warn_thr,
    output logic [CNT_W-1:0]  fire_thr,
    output logic              restart_req,
    output logic              sticky,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_WARN    = ADDR_W'(OFS_WARN);
    localparam logic [ADDR_W-1:0] A_FIRE    = ADDR_W'(OFS_FIRE);

    logic wr_ctrl, wr_status, wr_warn, wr_fire;

    always_comb begin
        wr_ctrl     = we && (addr == A_CTRL);
        wr_status   = we && (addr == A_STATUS);
        wr_warn     = we && (addr == A_WARN);
        wr_fire     = we && (addr == A_FIRE);
        restart_req = we && (addr == A_RESTART) && wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_run   <= 1'b0;
            en_irq   <= 1'b0;
            warn_thr <= '0;
            fire_thr <= '0;
        end else begin
            if (wr_ctrl) begin
                en_run <= wdata[0];
                en_irq <= wdata[1];
            end
            if (wr_warn) warn_thr <= wdata[CNT_W-1:0];
            if (wr_fire) fire_thr <= wdata[CNT_W-1:0];
        end
    end

    // Sticky fired flag: a new event outranks a software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      sticky <= 1'b0;
        else if (fire_evt)               sticky <= 1'b1;
        else if (wr_status && wdata[0])  sticky <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = DATA_W'({en_irq, en_run});
            A_STATUS: rdata = DATA_W'(sticky);
            A_WARN:   rdata = DATA_W'(warn_thr);
            A_FIRE:   rdata = DATA_W'(fire_thr);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clear)   cnt <= '0;
        else if (advance) cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_run,
    input  logic             en_irq,
    input  logic             restart_req,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] warn_thr,
    input  logic [CNT_W-1:0] fire_thr,
    output wd_state_e        state,
    output logic             cnt_clear,
    output logic             cnt_adv,
    output logic             fire_evt,
    output logic             bark_irq,
    output logic             bite_rst
);

    wd_state_e state_nx;
    logic      counting;
    logic      warn_hit;
    logic      fire_hit;

    always_comb begin
        counting = (state == WD_RUN) || (state == WD_WARNED);
        warn_hit = (state == WD_RUN) && en_run && !restart_req && (cnt == warn_thr);
        fire_hit = counting && en_run && !restart_req && (cnt == fire_thr);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            WD_OFF: begin
                if (en_run) state_nx = WD_RUN;
            end
            WD_RUN: begin
                if (!en_run)          state_nx = WD_OFF;
                else if (restart_req) state_nx = WD_RUN;
                else if (fire_hit)    state_nx = WD_FIRED;
                else if (warn_hit)    state_nx = WD_WARNED;
            end
            WD_WARNED: begin
                if (!en_run)          state_nx = WD_OFF;
                else if (restart_req) state_nx = WD_RUN;
                else if (fire_hit)    state_nx = WD_FIRED;
            end
            WD_FIRED: begin
                if (!en_run)          state_nx = WD_OFF;
                else if (restart_req) state_nx = WD_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= state_nx;
    end

    // Counter control and event strobe
    always_comb begin
        cnt_clear = (state == WD_OFF) || !en_run || restart_req;
        cnt_adv   = counting;
        fire_evt  = fire_hit;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bark_irq <= 1'b0;
            bite_rst <= 1'b0;
        end else begin
            bite_rst <= fire_hit;
            if (!en_run || restart_req)  bark_irq <= 1'b0;
            else if (warn_hit && en_irq) bark_irq <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bark_irq,
    output logic              bite_rst
);

    initial begin
        if (CNT_W < MIN_CNT_W || CNT_W > DATA_W)
            $error("wdog_two_stage: CNT_W must lie between %0d and DATA_W", MIN_CNT_W);
    end

    logic             en_run, en_irq, restart_req, sticky;
    logic             cnt_clear, cnt_adv, fire_evt;
    logic [CNT_W-1:0] warn_thr, fire_thr, cnt;
    wd_state_e        state;

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .fire_evt(fire_evt), .en_run(en_run), .en_irq(en_irq),
        .warn_thr(warn_thr), .fire_thr(fire_thr), .restart_req(restart_req),
        .sticky(sticky), .rdata(bus_rdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .advance(cnt_adv), .cnt(cnt)
    );

    wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_run(en_run), .en_irq(en_irq),
        .restart_req(restart_req), .cnt(cnt), .warn_thr(warn_thr), .fire_thr(fire_thr),
        .state(state), .cnt_clear(cnt_clear), .cnt_adv(cnt_adv), .fire_evt(fire_evt),
        .bark_irq(bark_irq), .bite_rst(bite_rst)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bark_irq,
    input logic             bite_rst,
    input logic             en_run,
    input logic             en_irq,
    input logic             restart_req,
    input logic             sticky,
    input logic [CNT_W-1:0] cnt,
    input wd_state_e        state
);

    // R3: the reset request is a single-cycle pulse
    assert_bite_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bite_rst |=> !bite_rst);

    // R4: the warning only rises if its enable was set at the deciding edge
    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bark_irq) |-> $past(en_irq));

    // R5: a restart write zeroes the count
    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (cnt == '0));

    // R6: two cycles disabled means quiet outputs
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_run && $past(!en_run)) |-> (!bark_irq && !bite_rst));

    // R9: once fired the count freezes until restart or disable
    assert_fired_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_FIRED && en_run && !restart_req) |=> $stable(cnt));

    // R10: the status flag is set whenever a request is out
    assert_sticky_on_bite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bite_rst |-> sticky);

endmodule

bind wdog_two_stage wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bark_irq(bark_irq), .bite_rst(bite_rst),
    .en_run(en_run), .en_irq(en_irq), .restart_req(restart_req),
    .sticky(sticky), .cnt(cnt), .state(state)
);

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bark_irq, bite_rst;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    string tag   = "R1 reset";

    always #2 clk = ~clk;

    wdog_two_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bark_irq(bark_irq), .bite_rst(bite_rst)
    );

    // Reference model, written from the requirements
    logic        m_run, m_ie, m_sticky, m_irq, m_bite;
    logic [31:0] m_warn, m_fire, m_cnt;
    int          m_st;   // 0 off, 1 run, 2 warned, 3 fired

    always @(posedge clk) begin : ref_model
        logic rs, hit_f, hit_w;
        int   nst;
        if (!rst_n) begin
            m_run <= 0; m_ie <= 0; m_sticky <= 0; m_irq <= 0; m_bite <= 0;
            m_warn <= 0; m_fire <= 0; m_cnt <= 0; m_st <= 0;
        end else begin
            rs    = bus_we && bus_addr == 8'h04 && bus_wdata[0];
            hit_f = (m_st == 1 || m_st == 2) && m_run && !rs && m_cnt == m_fire;
            hit_w = (m_st == 1) && m_run && !rs && m_cnt == m_warn;
            nst = m_st;
            if (m_st == 0)   nst = m_run ? 1 : 0;
            else if (!m_run) nst = 0;
            else if (rs)     nst = 1;
            else if (hit_f)  nst = 3;
            else if (hit_w)  nst = 2;
            m_st <= nst;
            if (!m_run || rs)       m_irq <= 0;
            else if (hit_w && m_ie) m_irq <= 1;
            if (m_st == 0 || !m_run || rs) m_cnt <= 0;
            else if (m_st != 3)            m_cnt <= m_cnt + 1;
            m_bite <= hit_f;
            if (hit_f) m_sticky <= 1;
            else if (bus_we && bus_addr == 8'h0C && bus_wdata[0]) m_sticky <= 0;
            if (bus_we && bus_addr == 8'h08) begin
                m_run <= bus_wdata[0];
                m_ie  <= bus_wdata[1];
            end
            if (bus_we && bus_addr == 8'h10) m_warn <= bus_wdata;
            if (bus_we && bus_addr == 8'h14) m_fire <= bus_wdata;
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h08:   return {30'd0, m_ie, m_run};
            8'h0C:   return {31'd0, m_sticky};
            8'h10:   return m_warn;
            8'h14:   return m_fire;
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            if (n_fails <= 25)
                $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Check at the falling edge, then drive the next cycle's inputs
    task automatic step(logic [7:0] a, logic w, logic [31:0] d);
        @(negedge clk);
        cmp("bark_irq", 32'(bark_irq), 32'(m_irq));
        cmp("bite_rst", 32'(bite_rst), 32'(m_bite));
        cmp("rdata",    bus_rdata,     exp_read(bus_addr));
        bus_addr = a; bus_we = w; bus_wdata = d;
    endtask

    task automatic idle(int n, logic [7:0] a);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'd0);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'h5EED_2024;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        tag = "R1 reset";
        step(8'h04, 0, 0); step(8'h08, 0, 0); step(8'h0C, 0, 0);
        step(8'h10, 0, 0); step(8'h14, 0, 0); idle(1, 8'h14);

        tag = "R11 wide threshold";
        wr(8'h14, 32'h1000_0000); idle(1, 8'h14);
        wr(8'h10, 32'h1FFF_FFFF); idle(1, 8'h10);

        tag = "R2 map";
        wr(8'h08, 32'hFFFF_FFF0); idle(1, 8'h08);
        wr(8'h08, 32'h0000_0000); idle(1, 8'h08);
        wr(8'h20, 32'hFFFF_FFFF); idle(1, 8'h20);
        wr(8'h04, 32'h0000_0001); idle(1, 8'h04);

        tag = "R3 bite timing";
        wr(8'h10, 4); wr(8'h14, 9); wr(8'h08, 1); idle(14, 8'h0C);

        tag = "R9 hold after bite";
        idle(10, 8'h0C);

        tag = "R4 warning";
        wr(8'h08, 0); idle(2, 8'h08);
        wr(8'h10, 3); wr(8'h14, 12); wr(8'h08, 3); idle(7, 8'h08);
        tag = "R5 restart";
        wr(8'h04, 1); idle(5, 8'h08);
        wr(8'h04, 2); idle(12, 8'h08);

        tag = "R6 disable";
        wr(8'h04, 1); idle(5, 8'h08);
        wr(8'h08, 2); idle(20, 8'h08);
        wr(8'h08, 3); idle(6, 8'h08);

        tag = "R7 equal thresholds";
        wr(8'h08, 0); wr(8'h10, 6); wr(8'h14, 6); wr(8'h08, 1); idle(10, 8'h0C);
        wr(8'h08, 0); wr(8'h08, 3); idle(10, 8'h0C);

        tag = "R8 warning above reset";
        wr(8'h08, 0); wr(8'h10, 20); wr(8'h14, 5); wr(8'h08, 3); idle(25, 8'h0C);

        tag = "R10 status";
        wr(8'h0C, 0); idle(1, 8'h0C);
        wr(8'h0C, 1); idle(1, 8'h0C);
        wr(8'h08, 0); wr(8'h10, 30); wr(8'h14, 3);
        wr(8'h0C, 1);
        wr(8'h08, 1); idle(4, 8'h0C);
        wr(8'h0C, 1); idle(3, 8'h0C);
        wr(8'h0C, 1); idle(2, 8'h0C);

        tag = "random R3 R4 R5 R6 R9 R10";
        for (int i = 0; i < 30000; i++) begin
            int unsigned r, sel;
            logic [7:0]  a;
            logic [31:0] d;
            r   = $urandom % 100;
            sel = $urandom % 7;
            case (sel)
                0: a = 8'h04;
                1: a = 8'h08;
                2: a = 8'h0C;
                3: a = 8'h10;
                4: a = 8'h14;
                5: a = 8'h08;
                default: a = 8'($urandom % 32);
            endcase
            d = $urandom;
            if (a == 8'h10 || a == 8'h14) d = ($urandom % 10 == 0) ? $urandom : ($urandom % 48);
            if (a == 8'h08) d = ($urandom % 5 == 0) ? 32'd0 : (($urandom % 2) ? 32'd3 : 32'd1);
            step(a, r < 6, d);
        end

        idle(2, 8'h0C);
        done = 1;
        summary();
        $finish;
    end

endmodule